// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Status Queue

This block is the receive half of an asynchronous serial port. It takes the raw serial line and a tick that runs at sixteen times the bit rate. It finds each start bit by its falling edge and confirms it with a vote of three centre samples, then clocks in eight or nine data bits least significant bit first. An optional parity bit is checked against even or odd parity, and the first stop bit is checked as well. Every finished character goes into a two-entry queue together with its own parity-error, stop-bit-error and ninth-bit flags, so the status that a reader sees always describes the character at the head of the queue.

The reader watches a ready flag, takes the head character and its flags from the outputs, and pulses a read strobe to advance the queue. If a character finishes while both entries are full, that character is discarded and a sticky overrun flag is raised; the next read clears it. Dropping the receiver enable stops reception at once, abandons any partly received character, empties the queue and clears the overrun flag.

Top module: `uart_rx_statfifo`

## Requirements
- R1: After reset, and while the receiver enable is low, rx_ready and overrun are both 0.
- R2: A frame of start bit, eight data bits sent least significant bit first, and a high stop bit, with parity disabled, appears on head_data with head_bit8, head_perr and head_ferr all 0, and rx_ready is set.
- R3: When nine_bit is 1, nine data bits are received; the first eight go to head_data and the ninth, the last one sent, goes to head_bit8. When nine_bit is 0, head_bit8 is 0.
- R4: With par_en set to 1, one parity bit follows the data bits. With par_odd set to 0 the data bits plus the parity bit must hold an even number of ones, and with par_odd set to 1 an odd number. head_perr is 1 when that count is wrong, and 0 otherwise.
- R5: The parity settings and nine_bit are captured when the start bit is confirmed. If they change later in the frame, that frame is not affected. With par_en set to 0 no parity bit is expected and head_perr is 0.
- R6: If the majority of the three centre samples of the first stop bit is low, the character is still stored, with head_ferr set to 1. The receiver then waits for the line to go high before it looks for a new start bit, so a line held low does not produce further characters.
- R7: A low pulse on the line shorter than the centre of a bit is treated as a false start. It stores no character, and reception works normally afterwards.
- R8: The queue holds two characters and keeps them in arrival order. Each character's flags move with it. rx_ready is 1 while at least one character is unread. Each pulse of rd_strobe removes the head, and reading until rx_ready falls empties the queue.
- R9: A character that finishes while both entries are full is dropped and overrun goes to 1. overrun stays 1 until a read removes a character, and that read clears it. If a read and the end of a character happen in the same cycle while the queue is full, the character is kept and overrun stays 0.
- R10: When rx_en goes low, the frame in progress is abandoned and the queue is emptied at once, so rx_ready and overrun are 0 on the next cycle. The abandoned frame is never delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rx_en | input | 1 | Receiver enable; low aborts reception and empties the queue |
| par_en | input | 1 | 1: a parity bit follows the data bits |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| nine_bit | input | 1 | 0: eight data bits, 1: nine data bits |
| rd_strobe | input | 1 | One-cycle pulse that removes the head character |
| head_data | output | 8 | Data byte of the head character (0 when empty) |
| head_bit8 | output | 1 | Ninth data bit of the head character |
| head_perr | output | 1 | Parity error of the head character |
| head_ferr | output | 1 | Stop-bit error of the head character |
| rx_ready | output | 1 | At least one unread character is held |
| overrun | output | 1 | Sticky: a character was dropped because the queue was full |

## Verification
Two functions can fall in the same cycle: a read that frees the head entry, and the end of a character while both entries are full. The bench fills the queue and sends a third character. It then moves a single read strobe one cycle at a time across the stop bit, over forty-one runs. After each run it reads back the queue and sorts the result as kept (two entries, the second being the new character) or dropped (one entry). It requires every run to give one of these two results with overrun clear, requires the result to switch from kept to dropped exactly once across the sweep, and relies on an in-line property to confirm that the coincident cycle keeps the character.

// File: rtl/uart_rx_statfifo.sv
module uart_rx_statfifo #(
  parameter int OSR   = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          nine_bit,
  input  logic          rd_strobe,
  output logic [DW-1:0] head_data,
  output logic          head_bit8,
  output logic          head_perr,
  output logic          head_ferr,
  output logic          rx_ready,
  output logic          overrun
);

  localparam int CW   = $clog2(OSR);
  localparam int SMID = OSR / 2;
  localparam int BW   = $clog2(DW + 1);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW   = $clog2(DEPTH + 1);
  localparam int EW   = DW + 3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT} st_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  logic [1:0]    sync;
  logic          line;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    vote;
  logic [BW-1:0] nb;
  logic [DW:0]   sh;
  logic          pen_l, podd_l, nine_l, perr_l;

  assign line = sync[1];

  wire in_win   = (cnt >= CW'(SMID - 1)) && (cnt <= CW'(SMID + 1));
  wire bit_end  = tick16 && (cnt == CW'(OSR - 1));
  wire stop_pt  = tick16 && (cnt == CW'(SMID + 1));
  wire maj_bit  = maj3(vote);
  wire maj_stop = maj3({vote[1:0], line});
  wire last_db  = (nb == (nine_l ? BW'(DW) : BW'(DW - 1)));
  wire [DW:0] dbits = nine_l ? sh : {1'b0, sh[DW:1]};

  wire frame_done = rx_en && (st == S_STOP) && stop_pt;
  wire [EW-1:0] entry = nine_l ? {~maj_stop, perr_l, sh[DW], sh[DW-1:0]}
                               : {~maj_stop, perr_l, 1'b0, sh[DW:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      vote   <= '0;
      nb     <= '0;
      sh     <= '0;
      pen_l  <= 1'b0;
      podd_l <= 1'b0;
      nine_l <= 1'b0;
      perr_l <= 1'b0;
    end else if (!rx_en) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (tick16) begin
      if (st == S_IDLE) begin
        if (!line) begin
          st   <= S_START;
          cnt  <= CW'(1);
          vote <= '0;
        end
      end else begin
        cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + CW'(1);
        if (in_win) vote <= {vote[1:0], line};
        case (st)
          S_START: if (bit_end) begin
            if (!maj_bit) begin
              st     <= S_DATA;
              nb     <= '0;
              pen_l  <= par_en;
              podd_l <= par_odd;
              nine_l <= nine_bit;
              perr_l <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end
          S_DATA: if (bit_end) begin
            sh <= {maj_bit, sh[DW:1]};
            nb <= nb + BW'(1);
            if (last_db) st <= pen_l ? S_PAR : S_STOP;
          end
          S_PAR: if (bit_end) begin
            perr_l <= (^dbits) ^ maj_bit ^ podd_l;
            st     <= S_STOP;
          end
          S_STOP: if (stop_pt) st <= maj_stop ? S_IDLE : S_WAIT;
          S_WAIT: if (line) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] fill;

  wire full = (fill == NW'(DEPTH));
  wire pop  = rx_en && rd_strobe && (fill != '0);
  wire push = frame_done && (!full || pop);
  wire drop = frame_done && full && !pop;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      fill    <= '0;
      overrun <= 1'b0;
    end else if (!rx_en) begin
      wp      <= '0;
      rp      <= '0;
      fill    <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      if (push && !pop)      fill <= fill + NW'(1);
      else if (pop && !push) fill <= fill - NW'(1);
      if (pop)       overrun <= 1'b0;
      else if (drop) overrun <= 1'b1;
    end
  end

  wire [EW-1:0] head = (fill != '0) ? mem[rp] : '0;
  assign head_data = head[DW-1:0];
  assign head_bit8 = head[DW];
  assign head_perr = head[DW+1];
  assign head_ferr = head[DW+2];
  assign rx_ready  = (fill != '0);

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= NW'(DEPTH)); // R8
  AST_FLUSH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_ready && !overrun && st == S_IDLE)); // R10
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rd_strobe && rx_ready) |=> !overrun); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_en && !rd_strobe) |=> overrun); // R9
  AST_POP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && frame_done) |=> (full && !overrun)); // R9
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && full && !rd_strobe) |=> full); // R9

endmodule

// File: tb/test_uart_rx_statfifo.sv
module test_uart_rx_statfifo;
  localparam int TDIV = 2;
  localparam int BT   = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, tick16 = 1'b0, rx_en = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, nine_bit = 1'b0, rd_strobe = 1'b0;
  logic [7:0] head_data;
  logic head_bit8, head_perr, head_ferr, rx_ready, overrun;

  int nchk = 0, nfail = 0, tc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tc     <= (tc == TDIV - 1) ? 0 : tc + 1;
    tick16 <= (tc == TDIV - 1);
  end

  uart_rx_statfifo i_uart_rx_statfifo (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .rx_en(rx_en),
    .par_en(par_en), .par_odd(par_odd), .nine_bit(nine_bit), .rd_strobe(rd_strobe),
    .head_data(head_data), .head_bit8(head_bit8), .head_perr(head_perr),
    .head_ferr(head_ferr), .rx_ready(rx_ready), .overrun(overrun));

  // nine, pen, podd, flip, stop, exp_perr, exp_ferr, data[8:0]
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    {7'b0000100, 9'h0A5},
    {7'b0000100, 9'h03C},
    {7'b0100100, 9'h007},
    {7'b0101110, 9'h055},
    {7'b0110100, 9'h081},
    {7'b0111110, 9'h0F0},
    {7'b1000100, 9'h1AB},
    {7'b1110100, 9'h1C3},
    {7'b1101110, 9'h100},
    {7'b0000001, 9'h042},
    {7'b0101011, 9'h099}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v);
    rxd = v;
    repeat (BT) @(negedge clk);
  endtask

  task automatic send(input logic nine, input logic wpar, input logic pbit,
                      input logic [8:0] d, input logic stop);
    hold(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) hold(d[i]);
    if (wpar) hold(pbit);
    hold(stop);
    rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
  endtask

  task automatic rd();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic pgood(input logic nine, input logic [8:0] d, input logic odd);
    return (nine ? ^d : ^d[7:0]) ^ odd;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", rx_ready, 0);
    chk("R1 overrun after reset", overrun, 0);
    rx_en = 1'b1;
    repeat (BT) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] e;
      string tg;
      e = VEC[v];
      nine_bit = e[15]; par_en = e[14]; par_odd = e[13];
      tg = e[9] ? "R6" : (e[14] ? "R4" : (e[15] ? "R3" : "R2"));
      send(e[15], e[14], pgood(e[15], e[8:0], e[13]) ^ e[12], e[8:0], e[11]);
      chk({tg, " ready"}, rx_ready, 1);
      chk({tg, " data"}, head_data, e[7:0]);
      chk({"R3 bit8 ", tg}, head_bit8, e[15] & e[8]);
      chk({tg, " perr"}, head_perr, e[10]);
      chk({tg, " ferr"}, head_ferr, e[9]);
      rd();
      chk({"R8 empty after read ", tg}, rx_ready, 0);
    end
    nine_bit = 0; par_en = 0; par_odd = 0;

    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
    chk("R7 false start ignored", rx_ready, 0);
    send(0, 0, 0, 9'h05A, 1);
    chk("R7 frame after false start", head_data, 8'h5A);
    rd();

    rxd = 1'b0;
    repeat (14 * BT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
    chk("R6 break ferr", head_ferr, 1);
    chk("R6 break data", head_data, 8'h00);
    rd();
    chk("R6 no extra frame while low", rx_ready, 0);

    par_en = 1;
    send(0, 1, ~pgood(0, 9'h012, 0), 9'h012, 1);
    send(0, 1, pgood(0, 9'h034, 0), 9'h034, 1);
    chk("R8 head first", head_data, 8'h12);
    chk("R8 head first perr", head_perr, 1);
    rd();
    chk("R8 head second", head_data, 8'h34);
    chk("R8 head second perr", head_perr, 0);
    chk("R8 ready second", rx_ready, 1);
    rd();
    chk("R8 drained", rx_ready, 0);
    par_en = 0;

    send(0, 0, 0, 9'h011, 1);
    send(0, 0, 0, 9'h022, 1);
    send(0, 0, 0, 9'h033, 1);
    chk("R9 overrun set", overrun, 1);
    chk("R9 head kept", head_data, 8'h11);
    rd();
    chk("R9 overrun cleared", overrun, 0);
    chk("R9 second kept", head_data, 8'h22);
    rd();
    chk("R9 third dropped", rx_ready, 0);

    par_en = 1; par_odd = 0;
    fork
      send(0, 1, 1'b1, 9'h00F, 1);
      begin repeat (3 * BT) @(negedge clk); par_en = 0; end
    join
    chk("R5 latched perr", head_perr, 1);
    chk("R5 latched parity bit consumed", head_ferr, 0);
    rd();
    fork
      send(0, 0, 0, 9'h0C6, 1);
      begin repeat (3 * BT) @(negedge clk); par_en = 1; end
    join
    chk("R5 late enable perr", head_perr, 0);
    chk("R5 late enable ferr", head_ferr, 0);
    chk("R5 late enable data", head_data, 8'hC6);
    rd();
    par_en = 0;

    send(0, 0, 0, 9'h077, 1);
    fork
      send(0, 0, 0, 9'h0FF, 1);
      begin
        repeat (3 * BT) @(negedge clk);
        rx_en = 0;
        @(negedge clk);
        chk("R10 flushed at once", rx_ready, 0);
        repeat (4) @(negedge clk);
        rx_en = 1;
      end
    join
    chk("R10 aborted frame lost", rx_ready, 0);
    send(0, 0, 0, 9'h066, 1);
    chk("R10 reception after enable", head_data, 8'h66);
    rd();
    send(0, 0, 0, 9'h011, 1);
    send(0, 0, 0, 9'h022, 1);
    send(0, 0, 0, 9'h033, 1);
    rx_en = 0;
    @(negedge clk);
    chk("R10 flush clears overrun", overrun, 0);
    chk("R10 flush empties", rx_ready, 0);
    rx_en = 1;
    @(negedge clk);

    begin
      int flips;
      bit prev, kept;
      flips = 0; prev = 1'b1;
      for (int k = 0; k <= 40; k++) begin
        rx_en = 0; @(negedge clk); rx_en = 1; @(negedge clk);
        send(0, 0, 0, 9'h011, 1);
        send(0, 0, 0, 9'h022, 1);
        fork
          send(0, 0, 0, 9'h033, 1);
          begin
            repeat (9 * BT + k) @(negedge clk);
            rd_strobe = 1; @(negedge clk); rd_strobe = 0;
          end
        join
        chk("R9 sweep overrun clear", overrun, 0);
        chk("R9 sweep head", head_data, 8'h22);
        rd();
        kept = rx_ready;
        if (kept) chk("R9 sweep kept char", head_data, 8'h33);
        if (k == 0)  chk("R9 early read keeps", kept, 1);
        if (k == 40) chk("R9 late read drops", kept, 0);
        if (kept != prev) flips++;
        prev = kept;
        if (kept) rd();
      end
      chk("R9 single kept/dropped boundary", flips, 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule